// File: doc/BRIEF.md
# Timed Fixed-Priority Grant Arbiter with Hold

This block hands out one exclusive grant among eight channels, for example a permit for one of eight generators to run. Each channel drives two inputs: a request, which asks for the grant, and a hold, which asks to keep the grant if the channel already owns it. A hold can keep an existing grant, but it can never win a new one.

The arbiter does not decide on every clock. An internal counter produces an evaluation tick once every `PERIOD` clock cycles. Request and hold are looked at only on that tick.

On a tick, the current owner keeps the grant if its request or its hold is set. Otherwise the grant goes to the highest-numbered channel that is requesting. If no channel is requesting, the grant is released. The result is a one-hot grant vector plus a valid flag.

Top module: `hold_prio_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set, and bit i means channel i owns the grant. `valid_o` is high exactly when a bit of `grant_o` is set.
- R2: `grant_o` changes only on the clock edge of an evaluation tick. Ticks fall every `PERIOD` cycles. Values on `req_i` and `hold_i` between ticks have no effect on the grant.
- R3: When a new owner is chosen, it is the highest-numbered channel whose `req_i` bit is set. Bit 7 beats bit 0.
- R4: On a tick, the current owner keeps the grant if its own `req_i` bit or its own `hold_i` bit is set.
- R5: A request from a higher-numbered channel does not take the grant from an owner that still requests.
- R6: A `hold_i` bit on a channel that does not own the grant never causes that channel to be granted.
- R7: If the owner releases on a tick and no request is set, `grant_o` becomes zero and `valid_o` goes low.
- R8: If the owner releases on a tick while other channels request, the new owner is granted on that same tick.
- R9: Reset sets the grant to zero and restarts the timer. After `rst_n` rises, reset leaves through a two-stage synchroniser. The first evaluation edge is clock edge `PERIOD+2` after the release, counting the first edge after the release as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| req_i | input | N_CH | Per-channel request |
| hold_i | input | N_CH | Per-channel keep-if-owned |
| grant_o | output | N_CH | One-hot grant |
| valid_o | output | 1 | A grant is active |

## Verification
The hardest situation to reach from the ports is an input change that falls strictly between two ticks. The tick is not visible at the ports. The bench therefore counts clock edges from the reset release and computes every evaluation edge from R9. Knowing where the ticks fall, it drives a disruptive pattern for a few cycles right after one tick and restores the inputs before the next, then confirms the grant never moved. The owner-versus-challenger cases are set up the same way: the bench lets a channel win on one tick, then presents higher requests or holds on the following tick.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_CH_DEFAULT     = 8;
  localparam int unsigned ARB_PERIOD_DEFAULT = 1000;
endpackage

// File: rtl/arb_eval_timer.sv
module arb_eval_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (at_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = at_end;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < (CW+1)'(PERIOD)); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o || (PERIOD == 1)); // R2
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N_CH = 8
) (
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] win_o
);
  logic [N_CH:0] above;

  assign above[N_CH] = 1'b0;

  for (genvar i = N_CH - 1; i >= 0; i--) begin : g_chain
    assign above[i] = above[i+1] | req_i[i];
    assign win_o[i] = req_i[i] & ~above[i+1];
  end
endmodule

// File: rtl/arb_grant_keeper.sv
module arb_grant_keeper #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] hold_i,
  input  logic [N_CH-1:0] pick_i,
  output logic [N_CH-1:0] grant_o,
  output logic            valid_o
);
  logic [N_CH-1:0] grant_q, grant_d;
  logic            owner_stays;
  logic [N_CH:0]   pick_ext;
  logic [N_CH-1:0] at_or_below;

  assign owner_stays = |(grant_q & (req_i | hold_i));

  always_comb begin
    grant_d = grant_q;
    if (tick_i) begin
      if (!owner_stays) grant_d = pick_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant_o = grant_q;
  assign valid_o = |grant_q;

  assign pick_ext    = {pick_i, 1'b0} - (N_CH+1)'(1);
  assign at_or_below = pick_ext[N_CH-1:0];

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R1
  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(grant_o)); // R2
  AST_PICK_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (|pick_i)) |-> ((req_i & ~at_or_below) == '0)); // R3
  AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (|(grant_o & (req_i | hold_i)))) |=> $stable(grant_o)); // R4
  AST_HOLD_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> ((grant_o & ~$past(grant_o) & ~$past(req_i)) == '0)); // R6
  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !(|(grant_o & hold_i)) && !(|req_i)) |=> !valid_o); // R7
endmodule

// File: rtl/hold_prio_arbiter.sv
module hold_prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_CH   = ARB_CH_DEFAULT,
  parameter int unsigned PERIOD = ARB_PERIOD_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] hold_i,
  output logic [N_CH-1:0] grant_o,
  output logic            valid_o
);
  logic            rst_meta_q, rst_sync_q;
  logic            tick;
  logic [N_CH-1:0] pick;

  // Reset: asserted at once, released on the second clock edge (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  arb_eval_timer #(.PERIOD(PERIOD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick_o (tick)
  );

  arb_prio_pick #(.N_CH(N_CH)) u_pick (
    .req_i (req_i),
    .win_o (pick)
  );

  arb_grant_keeper #(.N_CH(N_CH)) u_keep (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tick_i  (tick),
    .req_i   (req_i),
    .hold_i  (hold_i),
    .pick_i  (pick),
    .grant_o (grant_o),
    .valid_o (valid_o)
  );

  AST_VALID_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_o == (grant_o != '0)); // R1
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_sync_q |-> (grant_o == '0)); // R9
endmodule

// File: tb/hold_prio_arbiter_bench.sv
module hold_prio_arbiter_bench;
  localparam int unsigned NC = 8;
  localparam int unsigned P  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] req_i, hold_i;
  logic [NC-1:0] grant_o;
  logic          valid_o;

  int n_chk = 0;
  int n_bad = 0;
  int pc = 0;
  bit post_eval = 0;
  int n_done = 0;

  logic [NC-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  hold_prio_arbiter #(.N_CH(NC), .PERIOD(P)) u_hold_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .hold_i(hold_i),
    .grant_o(grant_o), .valid_o(valid_o)
  );

  // Edge counter from reset release; evaluation edges are P+2+m*P (R9).
  always @(posedge clk) begin
    if (!rst_n) begin
      pc = 0;
      post_eval = 0;
    end else begin
      pc = pc + 1;
      post_eval = (pc >= P + 2) && (((pc - (P + 2)) % P) == 0);
    end
  end

  task automatic check(input string tag, input logic [NC-1:0] exp_g);
    n_chk++;
    if (grant_o !== exp_g || valid_o !== (exp_g != '0)) begin
      n_bad++;
      $display("FAIL %s: grant=%h valid=%b expected grant=%h valid=%b",
               tag, grant_o, valid_o, exp_g, (exp_g != '0));
    end
  endtask

  // Monitor: compares after each evaluation edge.
  always @(negedge clk) begin
    if (post_eval && exp_q.size() > 0) begin
      check(tag_q.pop_front(), exp_q.pop_front());
      n_done++;
    end
  end

  // Driver: set inputs, queue expectation, wait for the evaluation.
  task automatic apply(input logic [NC-1:0] r, input logic [NC-1:0] h,
                       input logic [NC-1:0] e, input string tag);
    int target;
    target = n_done + 1;
    req_i  = r;
    hold_i = h;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait (n_done == target);
  endtask

  initial begin
    rst_n  = 1'b0;
    req_i  = '0;
    hold_i = '0;
    repeat (3) @(negedge clk);
    check("R9 reset clears grant", 8'h00);
    rst_n = 1'b1;
    req_i = 8'h01;
    repeat (5) @(negedge clk);
    check("R9 no grant before first tick", 8'h00);
    apply(8'h01, 8'h00, 8'h01, "R3 single request granted");
    apply(8'h81, 8'h00, 8'h01, "R5 owner not preempted");
    apply(8'h80, 8'h01, 8'h01, "R4 hold keeps owner");
    apply(8'h80, 8'h00, 8'h80, "R8 release hands over same tick");
    apply(8'h00, 8'h80, 8'h80, "R4 hold alone keeps");
    apply(8'h00, 8'h00, 8'h00, "R7 release with no request");
    apply(8'h00, 8'hFF, 8'h00, "R6 hold never wins");
    apply(8'h2C, 8'h00, 8'h20, "R3 highest of several");
    apply(8'h0C, 8'h00, 8'h08, "R8 next highest after release");
    apply(8'h00, 8'h00, 8'h00, "R7 idle again");
    apply(8'h55, 8'h00, 8'h40, "R3 alternating pattern");
    // Between ticks: disruptive inputs briefly, then restored (R2).
    @(negedge clk);
    req_i  = 8'h00;
    hold_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R2 grant steady between ticks", 8'h40);
    req_i = 8'h55;
    apply(8'h55, 8'h00, 8'h40, "R2 intermediate change ignored");
    apply(8'h80, 8'h00, 8'h80, "R1 one-hot after handover");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule